// File: doc/BRIEF.md
# Volume Command I2C Receiver

This block is a write-only I2C target that sets the volume of a two-channel stepped attenuator. It oversamples the open-drain SCL and SDA lines with the system clock and passes each line through a two-flop synchronizer and a short glitch filter. It finds start and stop conditions and accepts only one fixed 8-bit device address. It acknowledges that address and every byte after it. Each data byte that follows the address is decoded on its own as a volume command.

Each channel has a tens-of-dB field from 0 to 7 and a units-of-dB field from 0 to 9. The total attenuation is ten times the tens field plus the units field. A common mute flag covers both channels. A one-cycle strobe marks every clock in which any of these outputs takes a new value. A bus controller normally sends a tens command and then a units command in one transaction. For example, left at -33 dB is the byte 0xB3 followed by 0xA3.

Top module: `vol_cmd_i2c_rx`

## Requirements
- R1: After reset, all tens and units fields are 0, mute is off, `sda_oe` is low and `vol_upd` is low.
- R2: After a start, the block acknowledges the address byte 0x88, sent MSB first, by holding `sda_oe` high for the whole ninth SCL pulse. It gives no acknowledge to any other address, and it then ignores the bus until the next start.
- R3: Every data byte after a matched address is acknowledged. Any number of data bytes may follow before the stop, and each one is applied as a separate command.
- R4: Units commands carry the value in bits 3..0. Upper nibble 0xD sets both channels, 0xA sets the left channel, and 0x2 sets the right channel.
- R5: Tens commands have bit 3 at 0 and carry the value in bits 2..0. Upper nibble 0xE sets both channels, 0xB sets the left channel, and 0x3 sets the right channel.
- R6: The byte 0xFF sets both channels to tens 7 and units 9 (-79 dB) and leaves mute as it is.
- R7: The byte 0x79 turns mute on and 0x78 turns mute off.
- R8: A units value of 10 to 15, a tens command with bit 3 set, or any byte with no assigned meaning leaves every output unchanged. The byte is still acknowledged.
- R9: `vol_upd` pulses for one cycle exactly when a command changes at least one output. A command that changes nothing gives no pulse.
- R10: A start that arrives in the middle of a byte drops the partial byte, and the bytes that follow are taken as a fresh address phase.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| l_tens | output | 3 | Left attenuation, tens of dB |
| l_units | output | 4 | Left attenuation, units of dB |
| r_tens | output | 3 | Right attenuation, tens of dB |
| r_units | output | 4 | Right attenuation, units of dB |
| mute | output | 1 | Mute for both channels |
| vol_upd | output | 1 | One-cycle pulse when any output changes |

## Verification
A bit counter that is off by one shifts every received byte. The address check then fails, and the acknowledge is missing during the ninth pulse of that same byte, so the fault shows within one byte time. A decode error or a wrong command shows in the channel fields right after the acknowledge clock of the command. A strobe that fires without a change, or stays silent on a change, shows as a wrong pulse count once that transaction's stop has been sent. A filter or synchronizer fault shows up as an extra bit or a false start, and that corrupts the next command that is checked.

// File: rtl/vol_cmd_i2c_rx.sv
module vol_cmd_i2c_rx #(
  parameter logic [7:0] DEV_ADDR = 8'h88,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] l_tens,
  output logic [3:0] l_units,
  output logic [2:0] r_tens,
  output logic [3:0] r_units,
  output logic       mute,
  output logic       vol_upd
);

  logic [1:0]          scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_sh, sda_sh;
  logic                scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_sh <= '1; sda_sh <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_sh <= {scl_sh[FILT_LEN-2:0], scl_sy[1]};
      sda_sh <= {sda_sh[FILT_LEN-2:0], sda_sy[1]};
      if (&scl_sh) scl_f <= 1'b1; else if (~|scl_sh) scl_f <= 1'b0;
      if (&sda_sh) sda_f <= 1'b1; else if (~|sda_sh) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire start_det = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  wire scl_rise  = scl_f & ~scl_d;
  wire scl_fall  = ~scl_f & scl_d;

  logic       active, in_addr, apply;
  logic [3:0] bcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; in_addr <= 1'b0; apply <= 1'b0;
      bcnt <= '0; shreg <= '0; sda_oe <= 1'b0;
    end else begin
      apply <= 1'b0;
      if (start_det) begin
        active <= 1'b1; in_addr <= 1'b1; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        active <= 1'b0; bcnt <= '0; sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise && bcnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_f};
          bcnt  <= bcnt + 4'd1;
        end else if (scl_fall && bcnt == 4'd8) begin
          bcnt <= 4'd9;
          if (!in_addr) begin
            sda_oe <= 1'b1;
            apply  <= 1'b1;
          end else if (shreg == DEV_ADDR) begin
            sda_oe <= 1'b1;
          end else begin
            active <= 1'b0;
          end
        end else if (scl_fall && bcnt == 4'd9) begin
          sda_oe  <= 1'b0;
          bcnt    <= '0;
          in_addr <= 1'b0;
        end
      end
    end
  end

  logic [2:0] nlt, nrt;
  logic [3:0] nlu, nru;
  logic       nmute;
  wire        u_ok = shreg[3:0] <= 4'd9;
  wire        t_ok = ~shreg[3];

  always_comb begin
    nlt = l_tens; nlu = l_units; nrt = r_tens; nru = r_units; nmute = mute;
    if (apply) begin
      case (shreg[7:4])
        4'hD: if (u_ok) begin nlu = shreg[3:0]; nru = shreg[3:0]; end
        4'hA: if (u_ok) nlu = shreg[3:0];
        4'h2: if (u_ok) nru = shreg[3:0];
        4'hE: if (t_ok) begin nlt = shreg[2:0]; nrt = shreg[2:0]; end
        4'hB: if (t_ok) nlt = shreg[2:0];
        4'h3: if (t_ok) nrt = shreg[2:0];
        4'h7: if (shreg[3:1] == 3'b100) nmute = shreg[0];
        4'hF: if (shreg[3:0] == 4'hF) begin
          nlt = 3'd7; nrt = 3'd7; nlu = 4'd9; nru = 4'd9;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_tens <= '0; l_units <= '0; r_tens <= '0; r_units <= '0;
      mute <= 1'b0; vol_upd <= 1'b0;
    end else begin
      l_tens <= nlt; l_units <= nlu; r_tens <= nrt; r_units <= nru;
      mute <= nmute;
      vol_upd <= {nlt, nlu, nrt, nru, nmute} != {l_tens, l_units, r_tens, r_units, mute};
    end
  end

  // R2: the acknowledge level never moves while SCL is high
  a_r2_ack_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_d) |-> $stable(sda_oe));

  // R2: a stop releases SDA
  a_r2_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R8: units fields stay in the decimal range
  a_r8_units_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (l_units <= 4'd9) && (r_units <= 4'd9));

  // R9: a strobe comes with a changed output
  a_r9_upd_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    vol_upd |-> ({l_tens, l_units, r_tens, r_units, mute} !=
                 $past({l_tens, l_units, r_tens, r_units, mute})));

  // R9: without a strobe the outputs hold
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_upd |-> $stable({l_tens, l_units, r_tens, r_units, mute}));

endmodule

// File: tb/tb_vol_cmd_i2c_rx.sv
module tb_vol_cmd_i2c_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, mute, vol_upd;
  logic [2:0] l_tens, r_tens;
  logic [3:0] l_units, r_units;
  wire sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  vol_cmd_i2c_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .l_tens(l_tens), .l_units(l_units), .r_tens(r_tens), .r_units(r_units),
    .mute(mute), .vol_upd(vol_upd));

  int n_chk = 0, n_bad = 0, upd_cnt = 0, cyc = 0;
  localparam int H = 20;

  always @(posedge clk) begin
    if (vol_upd) upd_cnt <= upd_cnt + 1;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(H);
  endtask

  task automatic i_stop();
    m_sda = 1'b0; w(H); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic i_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H/2);
    ack = ~sda_line; w(H/2); m_scl = 1'b0; w(H);
  endtask

  function automatic logic [14:0] outs();
    return {l_tens, l_units, r_tens, r_units, mute};
  endfunction

  function automatic string req_of(input logic [7:0] c);
    case (c[7:4])
      4'hD, 4'hA, 4'h2: return (c[3:0] <= 4'd9) ? "R4" : "R8";
      4'hE, 4'hB, 4'h3: return c[3] ? "R8" : "R5";
      4'hF: return "R6";
      4'h7: return "R7";
      default: return "R8";
    endcase
  endfunction

  localparam int NV = 15;
  // {cmd, l_tens, l_units, r_tens, r_units, mute}
  localparam logic [22:0] VEC [NV] = '{
    {8'hD5, 3'd0, 4'd5, 3'd0, 4'd5, 1'b0},
    {8'hE3, 3'd3, 4'd5, 3'd3, 4'd5, 1'b0},
    {8'hA2, 3'd3, 4'd2, 3'd3, 4'd5, 1'b0},
    {8'hB6, 3'd6, 4'd2, 3'd3, 4'd5, 1'b0},
    {8'h29, 3'd6, 4'd2, 3'd3, 4'd9, 1'b0},
    {8'h31, 3'd6, 4'd2, 3'd1, 4'd9, 1'b0},
    {8'h79, 3'd6, 4'd2, 3'd1, 4'd9, 1'b1},
    {8'h78, 3'd6, 4'd2, 3'd1, 4'd9, 1'b0},
    {8'hFF, 3'd7, 4'd9, 3'd7, 4'd9, 1'b0},
    {8'hDC, 3'd7, 4'd9, 3'd7, 4'd9, 1'b0},
    {8'hE9, 3'd7, 4'd9, 3'd7, 4'd9, 1'b0},
    {8'h55, 3'd7, 4'd9, 3'd7, 4'd9, 1'b0},
    {8'hD0, 3'd7, 4'd0, 3'd7, 4'd0, 1'b0},
    {8'hE0, 3'd0, 4'd0, 3'd0, 4'd0, 1'b0},
    {8'hD0, 3'd0, 4'd0, 3'd0, 4'd0, 1'b0}
  };

  initial begin
    logic ack;
    logic [14:0] prev;
    int u0;
    w(5);
    chk("R1", outs(), 0);
    chk("R1", {sda_oe, vol_upd}, 0);
    rst_n = 1'b1;
    w(5);
    chk("R1", outs(), 0);

    for (int k = 0; k < NV; k++) begin
      prev = outs(); u0 = upd_cnt;
      i_start();
      i_byte(8'h88, ack); chk("R2", ack, 1);
      i_byte(VEC[k][22:15], ack); chk("R3", ack, 1);
      i_stop(); w(4);
      chk(req_of(VEC[k][22:15]), outs(), VEC[k][14:0]);
      chk("R9", upd_cnt - u0, (VEC[k][14:0] != prev) ? 1 : 0);
    end

    // R3: two commands in one transaction, left -33 dB
    u0 = upd_cnt;
    i_start();
    i_byte(8'h88, ack); chk("R2", ack, 1);
    i_byte(8'hB3, ack); chk("R3", ack, 1);
    i_byte(8'hA3, ack); chk("R3", ack, 1);
    i_stop(); w(4);
    chk("R3", outs(), {3'd3, 4'd3, 3'd0, 4'd0, 1'b0});
    chk("R9", upd_cnt - u0, 2);

    // R2: wrong address is not acknowledged and its data is ignored
    u0 = upd_cnt;
    i_start();
    i_byte(8'h8A, ack); chk("R2", ack, 0);
    i_byte(8'hD7, ack); chk("R2", ack, 0);
    i_stop(); w(4);
    chk("R2", outs(), {3'd3, 4'd3, 3'd0, 4'd0, 1'b0});
    chk("R9", upd_cnt - u0, 0);

    // R10: restart in the middle of a byte
    i_start();
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0;
    end
    w(H);
    i_start();
    i_byte(8'h88, ack); chk("R10", ack, 1);
    i_byte(8'h27, ack); chk("R10", ack, 1);
    i_stop(); w(4);
    chk("R10", outs(), {3'd3, 4'd3, 3'd0, 4'd7, 1'b0});

    // R11: one-cycle SCL spike during the low phase is filtered
    i_start();
    i_byte(8'h88, ack); chk("R11", ack, 1);
    m_sda = 1'b0; w(H/2);
    m_scl = 1'b1; w(1); m_scl = 1'b0; w(H/2);
    i_byte(8'hD4, ack); chk("R11", ack, 1);
    i_stop(); w(4);
    chk("R11", outs(), {3'd3, 4'd4, 3'd0, 4'd4, 1'b0});

    // R11: one-cycle SDA dip with SCL high is no start
    m_scl = 1'b1; w(H);
    m_sda = 1'b0; w(1); m_sda = 1'b1; w(H);
    i_byte(8'h88, ack); chk("R11", ack, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule